// File: doc/BRIEF.md
# Johnson Ring Counter with Illegal-State Trap

This block is a twisted-ring counter. A chain of `STAGES` flip-flops shifts by one place on each clock. The first stage takes the complement of the last stage, so the chain walks through `2*STAGES` patterns before it repeats. With three stages the counter divides by six, and with five stages it divides by ten.

The block has two kinds of output:
- The raw stage bits. These are symmetric square waves, each shifted by one clock from its neighbour.
- A vector of `2*STAGES` one-hot state lines. Each line comes from one two-input AND of neighbouring stage bits, so no line can glitch while the count advances.

A chain pattern that the counter can never reach by counting is flagged. On the next clock the chain is cleared to zero instead of circulating outside the legal ring. Parameters can select one decoded state as a synchronous terminal clear, which shortens the cycle. A parallel preset port lets a pattern be placed in the chain directly.

Top module: `johnson_ring`

## Requirements
- R1: A high `rst` at a rising edge makes `stageOut` all zero after that edge, and `stateHot` then shows state 0.
- R2: With no reset, load, trap or terminal clear, the next `stageOut` is the current value shifted one place toward the MSB. The inverse of the MSB (last stage) enters bit 0 (first stage).
- R3: From zero, and with no terminal clear, the chain visits state k for k = 0 .. 2N-1 and then returns to zero. Here N is `STAGES`. For k <= N, state k has ones in bits [k-1:0]. For k > N, it has ones in bits [N-1:k-N]. With N = 3 the order is 000, 001, 011, 111, 110, 100.
- R4: While the pattern is legal, exactly one `stateHot` bit is high, and it is bit k for state k as defined in R3.
- R5: Over one full count, each stage bit i is high for exactly N of the 2N clocks. Its first high clock after zero is step i+1, so neighbouring stages are one clock apart.
- R6: A pattern with more than one change between neighbouring bits along the chain (bit i against bit i+1, for i < N-1) is illegal. While such a pattern is held, `trapHit` is 1 and `stateHot` is all zero. The next state is all zero, unless reset or load acts.
- R7: A high `loadEn` at a rising edge, without reset, places `loadVal` in the chain after that edge, exactly as given.
- R8: When `TRUNC_EN` is 1 and the legal state `TRUNC_AT` is held, the next state is zero. The cycle then has `TRUNC_AT`+1 states.
- R9: The precedence order is reset, then load, then the illegal-state trap, then terminal clear, then shifting. A load issued while an illegal pattern is held therefore takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear to state 0 |
| loadEn | input | 1 | Parallel preset strobe |
| loadVal | input | STAGES | Pattern written by a preset |
| stageOut | output | STAGES | Raw chain bits; bit 0 is the first stage |
| stateHot | output | 2*STAGES | One-hot decoded state lines; bit k marks state k |
| trapHit | output | 1 | High while the chain holds an illegal pattern |

## Verification
An illegal pattern can line up with another action in the same cycle in two ways:
- A preset can arrive while the trap is asserted.
- In the three-stage truncated configuration, the pattern 101 drives the raw AND term of the terminal-clear state.

The bench provokes both:
- It presets an illegal pattern and follows it at once with a second preset of a legal pattern. That legal pattern must appear, not zero.
- It sweeps every pattern of both configurations by preset. For each one it judges the trap flag, the masked decoded lines and the following state, all against values derived from the state formula.

// File: rtl/johnson_pkg.sv
package johnson_pkg;

  // Command strobes issued by the control to the chain register.
  typedef struct packed {
    logic clear;
    logic load;
    logic shift;
  } ringCmd_t;

endpackage

// File: rtl/johnson_decode.sv
module johnson_decode #(
  parameter int STAGES = 5
) (
  input  logic [STAGES-1:0]   ringQ,
  output logic [2*STAGES-1:0] stateHot,
  output logic                legal
);
  localparam int STATES = 2 * STAGES;
  localparam int CW     = $clog2(STAGES + 1);

  logic [STAGES-2:0]  stepDiff;
  logic [CW-1:0]      diffCount;
  logic [STATES-1:0]  rawHot;

  // Changes between neighbouring bits along the chain (not around it).
  assign stepDiff = ringQ[STAGES-2:0] ^ ringQ[STAGES-1:1];

  always_comb begin
    diffCount = '0;
    for (int i = 0; i < STAGES - 1; i++) begin
      diffCount = diffCount + CW'(stepDiff[i]);
    end
  end

  assign legal = (diffCount <= CW'(1));

  // Each state is one AND of two neighbouring stage bits.
  for (genvar k = 0; k < STATES; k++) begin : g_term
    if (k == 0) begin : g_zero
      assign rawHot[k] = ~ringQ[STAGES-1] & ~ringQ[0];
    end else if (k < STAGES) begin : g_fill
      assign rawHot[k] = ringQ[k-1] & ~ringQ[k];
    end else if (k == STAGES) begin : g_full
      assign rawHot[k] = ringQ[STAGES-1] & ringQ[0];
    end else begin : g_drain
      assign rawHot[k] = ~ringQ[k-STAGES-1] & ringQ[k-STAGES];
    end
  end

  assign stateHot = legal ? rawHot : '0;

endmodule

// File: rtl/johnson_ctrl.sv
module johnson_ctrl
  import johnson_pkg::*;
#(
  parameter int STAGES   = 5,
  parameter bit TRUNC_EN = 1'b0,
  parameter int TRUNC_AT = 0
) (
  input  logic                rst,
  input  logic                loadEn,
  input  logic                legal,
  input  logic [2*STAGES-1:0] stateHot,
  output ringCmd_t            cmd
);
  localparam int STATES  = 2 * STAGES;
  localparam int HIT_IDX = (TRUNC_AT >= 0 && TRUNC_AT < STATES) ? TRUNC_AT : 0;

  logic truncHit;
  logic unusedHot;

  assign unusedHot = ^stateHot;

  if (TRUNC_EN) begin : g_trunc
    assign truncHit = stateHot[HIT_IDX];
  end else begin : g_notrunc
    assign truncHit = 1'b0;
  end

  always_comb begin
    cmd = '0;
    if (rst) begin
      cmd.clear = 1'b1;
    end else if (loadEn) begin
      cmd.load = 1'b1;
    end else if (!legal) begin
      cmd.clear = 1'b1;
    end else if (truncHit) begin
      cmd.clear = 1'b1;
    end else begin
      cmd.shift = 1'b1;
    end
  end

endmodule

// File: rtl/johnson_path.sv
module johnson_path
  import johnson_pkg::*;
#(
  parameter int STAGES = 5
) (
  input  logic              clk,
  input  ringCmd_t          cmd,
  input  logic [STAGES-1:0] loadVal,
  output logic [STAGES-1:0] ringQ
);
  always_ff @(posedge clk) begin
    if (cmd.clear) begin
      ringQ <= '0;
    end else if (cmd.load) begin
      ringQ <= loadVal;
    end else if (cmd.shift) begin
      ringQ <= {ringQ[STAGES-2:0], ~ringQ[STAGES-1]};
    end
  end

endmodule

// File: rtl/johnson_ring.sv
module johnson_ring
  import johnson_pkg::*;
#(
  parameter int STAGES   = 5,
  parameter bit TRUNC_EN = 1'b0,
  parameter int TRUNC_AT = 0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                loadEn,
  input  logic [STAGES-1:0]   loadVal,
  output logic [STAGES-1:0]   stageOut,
  output logic [2*STAGES-1:0] stateHot,
  output logic                trapHit
);
  ringCmd_t          cmd;
  logic              legal;
  logic [STAGES-1:0] ringQ;

  johnson_decode #(.STAGES(STAGES)) u_decode (
    .ringQ   (ringQ),
    .stateHot(stateHot),
    .legal   (legal)
  );

  johnson_ctrl #(
    .STAGES  (STAGES),
    .TRUNC_EN(TRUNC_EN),
    .TRUNC_AT(TRUNC_AT)
  ) u_ctrl (
    .rst     (rst),
    .loadEn  (loadEn),
    .legal   (legal),
    .stateHot(stateHot),
    .cmd     (cmd)
  );

  johnson_path #(.STAGES(STAGES)) u_path (
    .clk    (clk),
    .cmd    (cmd),
    .loadVal(loadVal),
    .ringQ  (ringQ)
  );

  assign stageOut = ringQ;
  assign trapHit  = ~legal;

endmodule

// File: rtl/johnson_ring_chk.sv
module johnson_ring_chk #(
  parameter int STAGES   = 5,
  parameter bit TRUNC_EN = 1'b0,
  parameter int TRUNC_AT = 0
) (
  input logic                clk,
  input logic                rst,
  input logic                loadEn,
  input logic [STAGES-1:0]   loadVal,
  input logic [STAGES-1:0]   stageOut,
  input logic [2*STAGES-1:0] stateHot,
  input logic                trapHit
);
  localparam int STATES  = 2 * STAGES;
  localparam int HIT_IDX = (TRUNC_AT >= 0 && TRUNC_AT < STATES) ? TRUNC_AT : 0;

  logic truncNow;
  assign truncNow = TRUNC_EN && stateHot[HIT_IDX];

  p_reset_zero_r1: assert property (@(posedge clk)
    rst |=> (stageOut == '0));

  p_shift_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!loadEn && !trapHit && !truncNow) |=>
      (stageOut == {$past(stageOut[STAGES-2:0]), ~$past(stageOut[STAGES-1])}));

  p_hot_single_r4: assert property (@(posedge clk) disable iff (rst)
    !trapHit |-> ($countones(stateHot) == 1));

  p_hot_masked_r6: assert property (@(posedge clk) disable iff (rst)
    trapHit |-> (stateHot == '0));

  p_trap_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (trapHit && !loadEn) |=> (stageOut == '0));

  p_preset_r7: assert property (@(posedge clk) disable iff (rst)
    loadEn |=> (stageOut == $past(loadVal)));

  if (TRUNC_EN) begin : g_trunc_chk
    p_trunc_clear_r8: assert property (@(posedge clk) disable iff (rst)
      (truncNow && !loadEn) |=> (stageOut == '0));
  end

endmodule

bind johnson_ring johnson_ring_chk #(
  .STAGES  (STAGES),
  .TRUNC_EN(TRUNC_EN),
  .TRUNC_AT(TRUNC_AT)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .loadEn  (loadEn),
  .loadVal (loadVal),
  .stageOut(stageOut),
  .stateHot(stateHot),
  .trapHit (trapHit)
);

// File: tb/johnson_ring_tb.sv
module johnson_ring_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic       rst5 = 1'b1, load5 = 1'b0;
  logic [4:0] val5 = '0;
  logic [4:0] q5;
  logic [9:0] hot5;
  logic       trap5;

  logic       rst3 = 1'b1, load3 = 1'b0;
  logic [2:0] val3 = '0;
  logic [2:0] q3;
  logic [5:0] hot3;
  logic       trap3;

  johnson_ring #(.STAGES(5)) u_dut (
    .clk(clk), .rst(rst5), .loadEn(load5), .loadVal(val5),
    .stageOut(q5), .stateHot(hot5), .trapHit(trap5)
  );

  johnson_ring #(.STAGES(3), .TRUNC_EN(1'b1), .TRUNC_AT(3)) u_dut3 (
    .clk(clk), .rst(rst3), .loadEn(load3), .loadVal(val3),
    .stageOut(q3), .stateHot(hot3), .trapHit(trap3)
  );

  function automatic int refState(int n, int k);
    if (k <= n) return (1 << k) - 1;
    return ((1 << n) - 1) & ~((1 << (k - n)) - 1);
  endfunction

  function automatic int legalIdx(int n, int p);
    for (int k = 0; k < 2 * n; k++) if (refState(n, k) == p) return k;
    return -1;
  endfunction

  function automatic int shiftNext(int n, int p);
    return ((p << 1) & ((1 << n) - 1)) | (((p >> (n - 1)) & 1) ^ 1);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int prev;
    int highCnt[5];
    int firstHigh[5];
    @(negedge clk);
    tick();
    // R1: reset state
    chk("R1 reset zero", 32'(q5), 0);
    chk("R1 reset decodes state 0", 32'(hot5), 1);
    chk("R1 no trap after reset", 32'(trap5), 0);
    rst5 = 1'b0;

    // R2 R3 R4 R5: two full counts of the 5-stage chain
    for (int i = 0; i < 5; i++) begin highCnt[i] = 0; firstHigh[i] = -1; end
    prev = -1;
    for (int step = 0; step < 20; step++) begin
      int k;
      k = step % 10;
      chk("R3 count order", 32'(q5), 32'(refState(5, k)));
      chk("R4 decoded line", 32'(hot5), 32'(1 << k));
      if (prev >= 0) chk("R2 shift rule", 32'(q5), 32'(shiftNext(5, prev)));
      if (step < 10) begin
        for (int i = 0; i < 5; i++) begin
          if (q5[i]) begin
            highCnt[i]++;
            if (firstHigh[i] < 0) firstHigh[i] = step;
          end
        end
      end
      prev = int'(q5);
      tick();
    end
    for (int i = 0; i < 5; i++) begin
      chk("R5 duty half", 32'(highCnt[i]), 5);
      chk("R5 phase step", 32'(firstHigh[i]), 32'(i + 1));
    end

    // R6 R7 R4: exhaustive preset sweep of the 5-stage chain
    for (int p = 0; p < 32; p++) begin
      int idx;
      idx = legalIdx(5, p);
      load5 = 1'b1; val5 = 5'(p);
      tick();
      load5 = 1'b0;
      chk("R7 preset value", 32'(q5), 32'(p));
      chk("R6 trap flag", 32'(trap5), (idx < 0) ? 1 : 0);
      chk("R6 R4 decoded lines", 32'(hot5), (idx < 0) ? 0 : 32'(1 << idx));
      tick();
      chk("R6 R2 next state", 32'(q5), (idx < 0) ? 0 : 32'(shiftNext(5, p)));
    end

    // R9: reset beats preset
    rst5 = 1'b1; load5 = 1'b1; val5 = 5'b00111;
    tick();
    rst5 = 1'b0;
    chk("R9 reset over preset", 32'(q5), 0);
    // R9: preset beats trap
    val5 = 5'b01010;
    tick();
    chk("R9 illegal preset held", 32'(trap5), 1);
    val5 = 5'b00011;
    tick();
    load5 = 1'b0;
    chk("R9 preset over trap", 32'(q5), 32'(5'b00011));

    // R8: truncated 3-stage chain counts 0,1,3,7 then repeats
    tick();
    rst3 = 1'b0;
    for (int step = 0; step < 8; step++) begin
      chk("R8 truncated order", 32'(q3), 32'(refState(3, step % 4)));
      tick();
    end
    // R6 R8: exhaustive preset sweep of the 3-stage chain
    for (int p = 0; p < 8; p++) begin
      int idx;
      int nxt;
      idx = legalIdx(3, p);
      if (idx < 0 || idx == 3) nxt = 0;
      else nxt = shiftNext(3, p);
      load3 = 1'b1; val3 = 3'(p);
      tick();
      load3 = 1'b0;
      chk("R6 trap flag 3-stage", 32'(trap3), (idx < 0) ? 1 : 0);
      chk("R4 decoded 3-stage", 32'(hot3), (idx < 0) ? 0 : 32'(1 << idx));
      tick();
      chk("R8 R6 next 3-stage", 32'(q3), 32'(nxt));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule